// File: doc/BRIEF.md
# Fractional-N Loop Divider and Band Controller

This block is the digital heart of a fractional-N frequency synthesizer. It takes a requested output frequency as an unsigned count of 10 Hz steps. The block checks the request against the legal 70 MHz to 100 MHz window. From an accepted word it takes an integer divide value and a 12-bit fraction. The 40.96 kHz comparison rate is exactly 4096 steps of 10 Hz, so the split is a plain bit slice. The block produces the comparison reference tick by dividing its own clock. A dual-modulus counter divides a stream of oscillator enable pulses by N or by N+1.

On every reference tick a 12-bit phase accumulator adds the fraction. Its carry selects N+1 for the next division, so the mean ratio is N + F/4096. The word also chooses one of four oscillator bands. The band pattern is sent MSB first over a three-wire serial-to-parallel register interface (clock, data, latch), followed by a completion strobe. A new word takes effect on the next reference tick: the integer, the fraction and the band change together, and the accumulator is cleared.

Top module: `frac_synth_core`

## Requirements
- R1: `ref_tick` is high for exactly one of every REF_DIV (262) clock cycles. It first rises in the 262nd cycle after reset release, which is counting cycle 261 from 0.
- R2: A word in the range 7,000,000 to 10,000,000 (inclusive) presented with `load_valid` is accepted. At the clock edge that ends the next `ref_tick` cycle, `int_n` becomes word[23:12] and `frac_f` becomes word[11:0]. Both are visible in the following cycle.
- R3: A word outside that range sets `range_err` one cycle after the load and leaves the pending word, `int_n`, `frac_f` and `band` unchanged. The next accepted load clears `range_err`.
- R4: `band` is 0 below 7,750,000, 1 below 8,500,000, 2 below 9,250,000, and 3 otherwise. A word exactly on a boundary takes the higher band.
- R5: On each `ref_tick` that is not an update, the accumulator adds `frac_f` modulo 4096 and `div_plus` takes the carry-out. An update clears the accumulator and `div_plus`. A fraction of 1024 gives `div_plus` high in exactly 2 of 8 consecutive reference periods.
- R6: `div_pulse` is high for one cycle after every completed division. A division ends on `vco_en` pulse number N (or N+1 when `div_plus` was high at the previous division end). It uses the `int_n` and `div_plus` values held when that previous division ended.
- R7: An update starts an 8-bit serial transfer. For band b, pattern bits 2b and 2b+1 are 1 and all other bits are 0. The transfer is MSB first. Each bit is set up with `ser_clk` low for one cycle, then held with `ser_clk` high for one cycle. `ser_latch` pulses for one cycle with `ser_clk` low after the last bit.
- R8: `done` pulses for one cycle, in the cycle right after `ser_latch`.
- R9: If two accepted loads arrive before a reference tick, only the later word is applied.
- R10: After reset, `int_n` = 1708, `frac_f` = 4032, `band` = 0, and `div_plus`, `range_err`, `ser_clk`, `ser_data`, `ser_latch`, `done` and `div_pulse` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_en | input | 1 | One pulse per divided oscillator edge |
| load_valid | input | 1 | Presents a new frequency word |
| freq_word | input | 24 | Target frequency in 10 Hz steps |
| ref_tick | output | 1 | Comparison reference tick |
| div_pulse | output | 1 | End of one loop division |
| div_plus | output | 1 | Next division uses N+1 |
| int_n | output | 12 | Active integer divide value |
| frac_f | output | 12 | Active fraction |
| band | output | 2 | Active oscillator band |
| range_err | output | 1 | Last load was out of range |
| ser_clk | output | 1 | Serial band register clock |
| ser_data | output | 1 | Serial band register data |
| ser_latch | output | 1 | Serial band register latch strobe |
| done | output | 1 | Band transfer complete |

## Verification
The in-RTL properties check several rules on every cycle:
- the reference tick never lasts two cycles;
- a division end always follows an enable pulse;
- the N+1 select rises only after a reference tick;
- a rejected word never disturbs the pending word;
- the latch and the serial clock never overlap, and data is steady while the serial clock is high;
- completion follows the latch;
- the band agrees with the integer divide value.

Some behaviours only the bench scenarios can show: the exact slicing of accepted words, the band choice on each boundary, the one-in-four carry pattern for a quarter fraction, the bit order of the serial pattern, and last-word-wins before a tick.

// File: rtl/frac_synth_pkg.sv
package frac_synth_pkg;
    typedef enum logic [2:0] {
        SH_IDLE,
        SH_SETUP,
        SH_HIGH,
        SH_LATCH,
        SH_DONE
    } sh_state_e;
endpackage

// File: rtl/frac_ref_div.sv
module frac_ref_div #(
    parameter int REF_DIV = 262
) (
    input  logic clk,
    input  logic rst_n,
    output logic ref_tick
);
    localparam int CW = $clog2(REF_DIV);
    localparam logic [CW-1:0] LAST = CW'(REF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } rd_state_t;

    rd_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.cnt == LAST) nxt_d.cnt = '0;
        else                   nxt_d.cnt = cur_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign ref_tick = (cur_q.cnt == LAST);

    AST_REF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> !ref_tick); // R1
endmodule

// File: rtl/frac_word_ctrl.sv
module frac_word_ctrl #(
    parameter int WORD_W   = 24,
    parameter int FRAC_W   = 12,
    parameter int MIN_WORD = 7000000,
    parameter int MAX_WORD = 10000000,
    parameter int BAND1    = 7750000,
    parameter int BAND2    = 8500000,
    parameter int BAND3    = 9250000,
    parameter int RST_WORD = 7000000,
    localparam int N_W     = WORD_W - FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              load_valid,
    input  logic [WORD_W-1:0] freq_word,
    input  logic              shift_busy,
    output logic [N_W-1:0]    int_n,
    output logic [FRAC_W-1:0] frac_f,
    output logic [1:0]        band,
    output logic              div_plus,
    output logic              range_err,
    output logic              apply,
    output logic [1:0]        apply_band
);
    localparam logic [N_W-1:0]    RST_N    = N_W'(RST_WORD >> FRAC_W);
    localparam logic [FRAC_W-1:0] RST_F    = FRAC_W'(RST_WORD % (1 << FRAC_W));
    localparam logic [1:0]        RST_BAND = (RST_WORD >= BAND3) ? 2'd3 :
                                             (RST_WORD >= BAND2) ? 2'd2 :
                                             (RST_WORD >= BAND1) ? 2'd1 : 2'd0;
    localparam logic [N_W-1:0]    N_B1     = N_W'(BAND1 >> FRAC_W);
    localparam logic [N_W-1:0]    N_B3     = N_W'(BAND3 >> FRAC_W);

    typedef struct packed {
        logic              pend;
        logic [WORD_W-1:0] pend_word;
        logic [N_W-1:0]    n;
        logic [FRAC_W-1:0] f;
        logic [1:0]        band;
        logic [FRAC_W-1:0] acc;
        logic              plus;
        logic              err;
    } wc_state_t;

    wc_state_t cur_q, nxt_d;

    function automatic logic [1:0] band_of(input logic [WORD_W-1:0] w);
        if (int'(w) >= BAND3)      return 2'd3;
        else if (int'(w) >= BAND2) return 2'd2;
        else if (int'(w) >= BAND1) return 2'd1;
        else                       return 2'd0;
    endfunction

    logic            in_range;
    logic [FRAC_W:0] sum;

    always_comb begin
        in_range   = (int'(freq_word) >= MIN_WORD) && (int'(freq_word) <= MAX_WORD);
        apply      = ref_tick && cur_q.pend && !shift_busy;
        apply_band = band_of(cur_q.pend_word);
        sum        = {1'b0, cur_q.acc} + {1'b0, cur_q.f};
        nxt_d      = cur_q;

        if (apply) begin
            nxt_d.n    = cur_q.pend_word[WORD_W-1:FRAC_W];
            nxt_d.f    = cur_q.pend_word[FRAC_W-1:0];
            nxt_d.band = apply_band;
            nxt_d.acc  = '0;
            nxt_d.plus = 1'b0;
            nxt_d.pend = 1'b0;
        end else if (ref_tick) begin
            nxt_d.acc  = sum[FRAC_W-1:0];
            nxt_d.plus = sum[FRAC_W];
        end

        if (load_valid) begin
            if (in_range) begin
                nxt_d.pend      = 1'b1;
                nxt_d.pend_word = freq_word;
                nxt_d.err       = 1'b0;
            end else begin
                nxt_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.pend      <= 1'b0;
            cur_q.pend_word <= WORD_W'(RST_WORD);
            cur_q.n         <= RST_N;
            cur_q.f         <= RST_F;
            cur_q.band      <= RST_BAND;
            cur_q.acc       <= '0;
            cur_q.plus      <= 1'b0;
            cur_q.err       <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign int_n     = cur_q.n;
    assign frac_f    = cur_q.f;
    assign band      = cur_q.band;
    assign div_plus  = cur_q.plus;
    assign range_err = cur_q.err;

    logic [WORD_W-1:0] pend_word_w;
    assign pend_word_w = cur_q.pend_word;

    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(range_err) |-> $stable(pend_word_w)); // R3
    AST_PLUS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_plus) |-> $past(ref_tick)); // R5
    AST_BAND_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (band == 2'd3) |-> (int_n >= N_B3)); // R4
    AST_BAND_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (band == 2'd0) |-> (int_n <= N_B1)); // R4
endmodule

// File: rtl/frac_mod_counter.sv
module frac_mod_counter #(
    parameter int N_W   = 12,
    parameter int RST_N = 1708
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vco_en,
    input  logic [N_W-1:0] int_n,
    input  logic           div_plus,
    output logic           div_pulse
);
    typedef struct packed {
        logic [N_W-1:0] cnt;
        logic [N_W-1:0] term;
        logic           pulse;
    } mc_state_t;

    mc_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.pulse = 1'b0;
        if (vco_en) begin
            if (cur_q.cnt == cur_q.term) begin
                nxt_d.cnt   = '0;
                nxt_d.pulse = 1'b1;
                nxt_d.term  = int_n - N_W'(1) + N_W'(div_plus);
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.cnt   <= '0;
            cur_q.term  <= N_W'(RST_N - 1);
            cur_q.pulse <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign div_pulse = cur_q.pulse;

    AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> $past(vco_en)); // R6
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse); // R6
endmodule

// File: rtl/frac_band_shifter.sv
module frac_band_shifter
    import frac_synth_pkg::*;
#(
    parameter int BAND_W = 2,
    localparam int NBANDS = 1 << BAND_W,
    localparam int SER_W  = 2 * NBANDS,
    localparam int IDX_W  = $clog2(SER_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BAND_W-1:0] band_in,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_latch,
    output logic              done,
    output logic              busy
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SER_W - 1);

    typedef struct packed {
        sh_state_e        st;
        logic [IDX_W-1:0] idx;
        logic [SER_W-1:0] pat;
        logic             sclk;
        logic             sdata;
        logic             latch;
        logic             done;
    } sh_state_t;

    sh_state_t        cur_q, nxt_d;
    logic [SER_W-1:0] new_pat;

    always_comb begin
        new_pat = '0;
        for (int b = 0; b < NBANDS; b++) begin
            if (band_in == BAND_W'(b)) begin
                new_pat[2*b]   = 1'b1;
                new_pat[2*b+1] = 1'b1;
            end
        end

        nxt_d = cur_q;
        case (cur_q.st)
            SH_IDLE: begin
                if (start) begin
                    nxt_d.st    = SH_SETUP;
                    nxt_d.idx   = '0;
                    nxt_d.pat   = new_pat;
                    nxt_d.sdata = new_pat[SER_W-1];
                    nxt_d.sclk  = 1'b0;
                end
            end
            SH_SETUP: begin
                nxt_d.st   = SH_HIGH;
                nxt_d.sclk = 1'b1;
            end
            SH_HIGH: begin
                nxt_d.sclk = 1'b0;
                if (cur_q.idx == LAST) begin
                    nxt_d.st    = SH_LATCH;
                    nxt_d.latch = 1'b1;
                end else begin
                    nxt_d.st    = SH_SETUP;
                    nxt_d.idx   = cur_q.idx + 1'b1;
                    nxt_d.pat   = {cur_q.pat[SER_W-2:0], 1'b0};
                    nxt_d.sdata = cur_q.pat[SER_W-2];
                end
            end
            SH_LATCH: begin
                nxt_d.st    = SH_DONE;
                nxt_d.latch = 1'b0;
                nxt_d.done  = 1'b1;
            end
            SH_DONE: begin
                nxt_d.st   = SH_IDLE;
                nxt_d.done = 1'b0;
            end
            default: nxt_d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st    <= SH_IDLE;
            cur_q.idx   <= '0;
            cur_q.pat   <= '0;
            cur_q.sclk  <= 1'b0;
            cur_q.sdata <= 1'b0;
            cur_q.latch <= 1'b0;
            cur_q.done  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ser_clk   = cur_q.sclk;
    assign ser_data  = cur_q.sdata;
    assign ser_latch = cur_q.latch;
    assign done      = cur_q.done;
    assign busy      = (cur_q.st != SH_IDLE);

    AST_LATCH_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ser_latch |-> !ser_clk); // R7
    AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_data)); // R7
    AST_DONE_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ser_latch)); // R8
endmodule

// File: rtl/frac_synth_core.sv
module frac_synth_core #(
    parameter int WORD_W   = 24,
    parameter int FRAC_W   = 12,
    parameter int REF_DIV  = 262,
    parameter int MIN_WORD = 7000000,
    parameter int MAX_WORD = 10000000,
    parameter int BAND1    = 7750000,
    parameter int BAND2    = 8500000,
    parameter int BAND3    = 9250000,
    parameter int RST_WORD = 7000000,
    localparam int N_W     = WORD_W - FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vco_en,
    input  logic              load_valid,
    input  logic [WORD_W-1:0] freq_word,
    output logic              ref_tick,
    output logic              div_pulse,
    output logic              div_plus,
    output logic [N_W-1:0]    int_n,
    output logic [FRAC_W-1:0] frac_f,
    output logic [1:0]        band,
    output logic              range_err,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_latch,
    output logic              done
);
    logic       apply;
    logic [1:0] apply_band;
    logic       shift_busy;

    frac_ref_div #(.REF_DIV(REF_DIV)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick)
    );

    frac_word_ctrl #(
        .WORD_W   (WORD_W),
        .FRAC_W   (FRAC_W),
        .MIN_WORD (MIN_WORD),
        .MAX_WORD (MAX_WORD),
        .BAND1    (BAND1),
        .BAND2    (BAND2),
        .BAND3    (BAND3),
        .RST_WORD (RST_WORD)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick   (ref_tick),
        .load_valid (load_valid),
        .freq_word  (freq_word),
        .shift_busy (shift_busy),
        .int_n      (int_n),
        .frac_f     (frac_f),
        .band       (band),
        .div_plus   (div_plus),
        .range_err  (range_err),
        .apply      (apply),
        .apply_band (apply_band)
    );

    frac_mod_counter #(
        .N_W   (N_W),
        .RST_N (RST_WORD >> FRAC_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .vco_en    (vco_en),
        .int_n     (int_n),
        .div_plus  (div_plus),
        .div_pulse (div_pulse)
    );

    frac_band_shifter #(.BAND_W(2)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (apply),
        .band_in   (apply_band),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_latch (ser_latch),
        .done      (done),
        .busy      (shift_busy)
    );
endmodule

// File: tb/frac_synth_core_tb_top.sv
module frac_synth_core_tb_top;
    localparam int REF_DIV = 262;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vco_en = 1'b0;
    logic        load_valid = 1'b0;
    logic [23:0] freq_word = '0;
    logic        ref_tick, div_pulse, div_plus, range_err;
    logic        ser_clk, ser_data, ser_latch, done;
    logic [11:0] int_n, frac_f;
    logic [1:0]  band;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    frac_synth_core dut_i (
        .clk(clk), .rst_n(rst_n), .vco_en(vco_en), .load_valid(load_valid),
        .freq_word(freq_word), .ref_tick(ref_tick), .div_pulse(div_pulse),
        .div_plus(div_plus), .int_n(int_n), .frac_f(frac_f), .band(band),
        .range_err(range_err), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch(ser_latch), .done(done)
    );

    // behavioural reference model
    int m_r, m_pend, m_pw, m_n, m_f, m_band, m_acc, m_plus, m_err;
    int m_cnt, m_term, m_pulse, m_s, m_pat, m_sdata;

    function automatic int band_for(int w);
        if (w >= 9250000) return 3;
        if (w >= 8500000) return 2;
        if (w >= 7750000) return 1;
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_r = 0; m_pend = 0; m_pw = 7000000; m_n = 1708; m_f = 4032;
            m_band = 0; m_acc = 0; m_plus = 0; m_err = 0;
            m_cnt = 0; m_term = 1707; m_pulse = 0; m_s = 0; m_pat = 0; m_sdata = 0;
        end else begin
            int  w;
            bit  tick, apply, lok;
            w     = int'(freq_word);
            tick  = (m_r == REF_DIV - 1);
            m_r   = tick ? 0 : m_r + 1;
            apply = tick && (m_pend != 0) && (m_s == 0);
            lok   = load_valid && w >= 7000000 && w <= 10000000;
            if (vco_en) begin
                if (m_cnt == m_term) begin
                    m_cnt = 0; m_pulse = 1; m_term = m_n - 1 + m_plus;
                end else begin
                    m_cnt++; m_pulse = 0;
                end
            end else m_pulse = 0;
            if (m_s != 0) m_s = (m_s == 18) ? 0 : m_s + 1;
            if (apply) begin
                m_n = m_pw / 4096; m_f = m_pw % 4096; m_band = band_for(m_pw);
                m_acc = 0; m_plus = 0; m_pend = 0;
                m_pat = 3 << (2 * m_band); m_s = 1;
            end else if (tick) begin
                m_acc = m_acc + m_f;
                m_plus = (m_acc >= 4096) ? 1 : 0;
                m_acc = m_acc % 4096;
            end
            if (m_s >= 1 && m_s <= 16 && (m_s % 2) == 1)
                m_sdata = (m_pat >> (7 - (m_s - 1) / 2)) & 1;
            if (load_valid) begin
                if (lok) begin m_pend = 1; m_pw = w; m_err = 0; end
                else m_err = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !finished) begin
            int e_clk, e_latch, e_done;
            e_clk   = (m_s >= 1 && m_s <= 16 && (m_s % 2) == 0) ? 1 : 0;
            e_latch = (m_s == 17) ? 1 : 0;
            e_done  = (m_s == 18) ? 1 : 0;
            chk(ref_tick == (m_r == REF_DIV - 1), "R1 ref_tick", ref_tick, m_r == REF_DIV - 1);
            chk(int'(int_n) == m_n, "R2 int_n", int_n, m_n);
            chk(int'(frac_f) == m_f, "R2 frac_f", frac_f, m_f);
            chk(int'(range_err) == m_err, "R3 range_err", range_err, m_err);
            chk(int'(band) == m_band, "R4 band", band, m_band);
            chk(int'(div_plus) == m_plus, "R5 div_plus", div_plus, m_plus);
            chk(int'(div_pulse) == m_pulse, "R6 div_pulse", div_pulse, m_pulse);
            chk(int'(ser_clk) == e_clk, "R7 ser_clk", ser_clk, e_clk);
            chk(int'(ser_data) == m_sdata, "R7 ser_data", ser_data, m_sdata);
            chk(int'(ser_latch) == e_latch, "R7 ser_latch", ser_latch, e_latch);
            chk(int'(done) == e_done, "R8 done", done, e_done);
        end
    end

    always @(negedge clk) vco_en <= ((cyc % 5) != 2);

    task automatic load(input int w);
        @(negedge clk);
        load_valid = 1'b1;
        freq_word  = 24'(w);
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (done) return;
        end
        chk(0, "R8 done timeout", 0, 1);
    endtask

    task automatic apply_word(input int w, input int exp_band, input string tag);
        load(w);
        wait_done();
        @(negedge clk);
        chk(int'(int_n) == w / 4096, {tag, " int_n"}, int_n, w / 4096);
        chk(int'(frac_f) == w % 4096, {tag, " frac_f"}, frac_f, w % 4096);
        chk(int'(band) == exp_band, {tag, " band"}, band, exp_band);
    endtask

    // serial capture of one transfer
    int sh_bits, sh_val;
    always @(posedge ser_clk) begin
        sh_val  = (sh_val << 1) | int'(ser_data);
        sh_bits = sh_bits + 1;
    end

    initial begin
        sh_bits = 0; sh_val = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(int'(int_n) == 1708 && int'(frac_f) == 4032 && band == 2'd0, "R10 reset settings",
            int_n, 1708);
        chk(!div_plus && !range_err && !ser_clk && !ser_data && !ser_latch && !done && !div_pulse,
            "R10 reset outputs", 1, 0);
        rst_n = 1'b1;

        // R1 first tick at counting cycle 261
        begin
            int n;
            n = 0;
            while (!ref_tick && n < 400) begin @(negedge clk); n++; end
            chk(n == 261, "R1 first tick cycle", n, 261);
        end

        // R2/R5/R7 quarter fraction, band 1
        sh_bits = 0; sh_val = 0;
        apply_word(2000 * 4096 + 1024, 1, "R2 quarter");
        chk(sh_bits == 8 && sh_val == 8'h0C, "R7 serial pattern band1", sh_val, 8'h0C);
        begin
            int ticks, plus_cnt;
            ticks = 0; plus_cnt = 0;
            while (!ref_tick) @(negedge clk);
            @(negedge clk);
            while (ticks < 8) begin
                @(negedge clk);
                if (ref_tick) begin ticks++; if (div_plus) plus_cnt++; end
            end
            chk(plus_cnt == 2, "R5 one in four carries", plus_cnt, 2);
        end

        // R4 boundaries
        apply_word(7749999, 0, "R4 below 77.5");
        apply_word(7750000, 1, "R4 at 77.5");
        apply_word(8500000, 2, "R4 at 85");
        sh_bits = 0; sh_val = 0;
        apply_word(9250000, 3, "R4 at 92.5");
        chk(sh_val == 8'hC0, "R7 serial pattern band3", sh_val, 8'hC0);
        apply_word(10000000, 3, "R2 top edge");
        apply_word(7000000, 0, "R2 bottom edge");

        // R3 rejection
        load(6999999);
        chk(range_err == 1'b1, "R3 low reject flag", range_err, 1);
        repeat (300) @(negedge clk);
        chk(int'(int_n) == 1708 && int'(frac_f) == 4032, "R3 settings kept", int_n, 1708);
        load(10000001);
        chk(range_err == 1'b1, "R3 high reject flag", range_err, 1);
        repeat (300) @(negedge clk);
        chk(band == 2'd0 && int'(int_n) == 1708, "R3 band kept", band, 0);
        load(8000000);
        chk(range_err == 1'b0, "R3 cleared by accept", range_err, 0);
        wait_done();

        // R9 last word wins
        while (ref_tick) @(negedge clk);
        load(9000000);
        load(8888888);
        wait_done();
        @(negedge clk);
        chk(int'(int_n) == 8888888 / 4096 && int'(frac_f) == 8888888 % 4096,
            "R9 later word applied", int_n, 8888888 / 4096);

        // R6 long run with a nonzero fraction
        apply_word(9876543, 3, "R6 setup");
        repeat (3000) @(negedge clk);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule